// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the bus-facing register file of a small serial port. A processor reaches it through a byte-wide bus with separate read and write strobes. Each register sits in its own 32-bit aligned slot but holds only eight bits. The slots give four identification bytes, a data port, a combined status/control byte and a 16-bit baud divisor split into two bytes. The divisor is driven out to the bit-timing logic, which is not part of this block.

Behind the data port, received bytes collect in a four-entry FIFO, and each read of the data slot takes one out. Transmit has a single holding byte, which a serializer collects through a request/done handshake. Receive errors are kept as sticky flags. A single interrupt line merges receive events with a transmit-room event. Each direction has its own enable in the status byte.

Top module: `uart_reg_frontend`

## Requirements
- R1: Slot index is address bits [4:2]. Slots 0 to 3 return the bytes of parameter ID_WORD, least significant byte in slot 0. Writes to these slots leave them unchanged.
- R2: Slot 6 holds divisor bits [7:0] and slot 7 holds bits [15:8]. Both can be written and read back. Output baud_div carries the whole 16-bit value from the cycle after the write.
- R3: The status byte (slot 5) reports the receive FIFO level. Bit 3 is 1 when 4 bytes are held, bit 4 is 1 when exactly 3 are held, and bit 5 is 1 when none are held.
- R4: Received bytes come out of the data slot (slot 4) in arrival order, and each data read removes one byte. The FIFO holds up to 4 bytes.
- R5: A byte that arrives while 4 bytes are held and no read is taking place is dropped. The stored bytes are kept and status bit 1 (overrun) is set.
- R6: A byte pushed with rx_frame_err high is stored like any other byte, and it sets status bit 0 (frame error).
- R7: Status bits 0 and 1 are sticky. A status write with a 0 in such a bit clears it, and a 1 leaves it as it was. Bits 3, 4, 5 and 7 ignore writes. Bits 2 (receive interrupt enable) and 6 (transmit interrupt enable) take the written value.
- R8: A data read while the FIFO is empty returns the byte most recently removed (0 after reset) and leaves the FIFO empty.
- R9: A data write is accepted only when status bit 7 (transmit empty) is 1. After it is accepted, tx_req is 1, tx_byte holds the byte and bit 7 reads 0. Data writes while bit 7 is 0 are ignored. A tx_done pulse returns bit 7 to 1 and drops tx_req.
- R10: With bit 2 set, irq is 1 whenever the FIFO holds data or either error flag is set. With bit 2 clear, receive events do not raise irq.
- R11: irq is 1 whenever bit 6 and bit 7 are both 1. Otherwise transmit does not raise it.
- R12: After reset, status reads 0xA0, irq and tx_req are 0 and baud_div is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] pick the slot |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a data-slot read removes one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Combined receive/transmit interrupt |
| rx_push | input | 1 | A received byte is presented |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Received byte had no valid stop bit |
| tx_req | output | 1 | Holding byte is waiting to be sent |
| tx_byte | output | 8 | Byte to serialize |
| tx_done | input | 1 | Serializer has shifted the held byte out |
| baud_div | output | 16 | Baud divisor value |

## Verification
Read data depends only on the address and the current state, so it is valid in the same cycle as the strobe. The removal that a data read causes shows up after the next rising edge. Writes, pushes and tx_done pulses change the registered state at the following rising edge. irq, tx_req, tx_byte and baud_div are formed from that state, so every result is due one edge after its stimulus. The bench drives each stimulus at a falling edge and holds it over exactly one rising edge. It samples the results at the next falling edge, or 1 time unit after the strobe for read data.

// File: rtl/urf_pkg.sv
// Package: shared slot indices and status bit positions for the UART front end.
// Assumes: slot index is bus address bits [4:2]; the status bit positions
// below are decoded by software and must not move.
package urf_pkg;
    localparam int BYTE_W = 8;

    localparam int SLOT_ID0  = 0;
    localparam int SLOT_ID1  = 1;
    localparam int SLOT_ID2  = 2;
    localparam int SLOT_ID3  = 3;
    localparam int SLOT_DATA = 4;
    localparam int SLOT_STAT = 5;
    localparam int SLOT_BDLO = 6;
    localparam int SLOT_BDHI = 7;

    localparam int ST_FERR   = 0;
    localparam int ST_OERR   = 1;
    localparam int ST_RXIE   = 2;
    localparam int ST_RXFULL = 3;
    localparam int ST_RXLAST = 4;
    localparam int ST_RXMT   = 5;
    localparam int ST_TXIE   = 6;
    localparam int ST_TXMT   = 7;
endpackage

// File: rtl/urf_rx_fifo.sv
// Module: receive byte queue with a last-read register.
// Does: stores up to DEPTH bytes in arrival order and drops a byte that
// arrives when full unless a pop frees room in the same cycle.
// Assumes: pop is only meaningful when not empty; an empty pop is a no-op and
// dout then shows the byte most recently popped.
module urf_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         one_free,
    output logic                         empty,
    output logic                         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     last_q;
    logic             do_pop, do_push;

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign one_free = (cnt_q == CNT_W'(DEPTH - 1));
    assign count    = cnt_q;
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign overflow = push && full && !do_pop;
    assign dout     = empty ? last_q : mem[rd_ptr];

    // Storage write: place the accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers, level and last-read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
                last_q <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // A dropped byte must leave the level at full.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(rd_ptr)));

    // A pop on an empty queue leaves it empty and keeps the shown byte.
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(dout)));
endmodule

// File: rtl/urf_tx_hold.sv
// Module: single-byte transmit holding register with request/done handshake.
// Does: captures a byte on load when empty, raises the request until the
// serializer pulses done, and ignores loads while a byte is pending.
// Assumes: done is only pulsed while a byte is pending.
module urf_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         done,
    output logic         empty,
    output logic [W-1:0] hold,
    output logic         req
);
    logic pend_q;

    assign empty = !pend_q;
    assign req   = pend_q;

    // Pending flag and held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold   <= '0;
        end else if (pend_q) begin
            if (done) pend_q <= 1'b0;
        end else if (load) begin
            pend_q <= 1'b1;
            hold   <= din;
        end
    end

    // A load during a pending byte must not disturb it.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && load && !done) |=> (pend_q && $stable(hold)));
endmodule

// File: rtl/urf_status.sv
// Module: status control bits and combined interrupt.
// Does: keeps the two sticky error flags and the two interrupt enables, and
// merges receive and transmit conditions onto one interrupt line.
// Assumes: event inputs are single-cycle; an event wins over a clearing
// write in the same cycle.
module urf_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       frame_evt,
    input  logic       overrun_evt,
    input  logic       rx_avail,
    input  logic       tx_empty,
    output logic       ferr,
    output logic       oerr,
    output logic       rx_ie,
    output logic       tx_ie,
    output logic       irq
);
    import urf_pkg::*;

    // Sticky error flags and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr  <= 1'b0;
            oerr  <= 1'b0;
            rx_ie <= 1'b0;
            tx_ie <= 1'b0;
        end else begin
            ferr <= frame_evt   || (ferr && !(wr_en && !wdata[ST_FERR]));
            oerr <= overrun_evt || (oerr && !(wr_en && !wdata[ST_OERR]));
            if (wr_en) begin
                rx_ie <= wdata[ST_RXIE];
                tx_ie <= wdata[ST_TXIE];
            end
        end
    end

    // Interrupt merge: receive condition or transmit room.
    always_comb begin
        irq = (rx_ie && (rx_avail || ferr || oerr)) || (tx_ie && tx_empty);
    end

    // Error flags hold without a status write.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && oerr && !wr_en) |=> (ferr && oerr));
endmodule

// File: rtl/uart_reg_frontend.sv
// Module: UART register file and interrupt front end (top).
// Does: decodes word-aligned byte registers, feeds the receive queue and the
// transmit holding byte, and drives the baud divisor and interrupt.
// Assumes: bus strobes last one cycle per access; read data is combinational.
module uart_reg_frontend #(
    parameter int          ADDR_W   = 5,
    parameter int          RX_DEPTH = 4,
    parameter logic [31:0] ID_WORD  = 32'h5A01C37E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_frame_err,
    output logic              tx_req,
    output logic [7:0]        tx_byte,
    input  logic              tx_done,
    output logic [15:0]       baud_div
);
    import urf_pkg::*;

    localparam int CNT_W = $clog2(RX_DEPTH + 1);

    logic [ADDR_W-1:0] slot;
    logic              sel_data, sel_stat, sel_bdlo, sel_bdhi;
    logic [7:0]        rx_dout;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_full, rx_one_free, rx_empty, rx_ovf;
    logic              tx_empty;
    logic              ferr, oerr, rx_ie, tx_ie;
    logic [7:0]        status;
    logic [15:0]       baud_q;

    assign slot     = bus_addr >> 2;
    assign sel_data = (slot == ADDR_W'(SLOT_DATA));
    assign sel_stat = (slot == ADDR_W'(SLOT_STAT));
    assign sel_bdlo = (slot == ADDR_W'(SLOT_BDLO));
    assign sel_bdhi = (slot == ADDR_W'(SLOT_BDHI));
    assign baud_div = baud_q;

    urf_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .din      (rx_byte),
        .pop      (bus_rd && sel_data),
        .dout     (rx_dout),
        .count    (rx_count),
        .full     (rx_full),
        .one_free (rx_one_free),
        .empty    (rx_empty),
        .overflow (rx_ovf)
    );

    urf_tx_hold #(.W(BYTE_W)) u_txh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bus_wr && sel_data),
        .din   (bus_wdata),
        .done  (tx_done),
        .empty (tx_empty),
        .hold  (tx_byte),
        .req   (tx_req)
    );

    urf_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr && sel_stat),
        .wdata       (bus_wdata),
        .frame_evt   (rx_push && rx_frame_err),
        .overrun_evt (rx_ovf),
        .rx_avail    (!rx_empty),
        .tx_empty    (tx_empty),
        .ferr        (ferr),
        .oerr        (oerr),
        .rx_ie       (rx_ie),
        .tx_ie       (tx_ie),
        .irq         (irq)
    );

    // Baud divisor bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_q <= '0;
        end else if (bus_wr) begin
            if (sel_bdlo) baud_q[7:0]  <= bus_wdata;
            if (sel_bdhi) baud_q[15:8] <= bus_wdata;
        end
    end

    // Assemble the status byte.
    always_comb begin
        status             = '0;
        status[ST_FERR]    = ferr;
        status[ST_OERR]    = oerr;
        status[ST_RXIE]    = rx_ie;
        status[ST_RXFULL]  = rx_full;
        status[ST_RXLAST]  = rx_one_free;
        status[ST_RXMT]    = rx_empty;
        status[ST_TXIE]    = tx_ie;
        status[ST_TXMT]    = tx_empty;
    end

    // Read multiplexer over the slots.
    always_comb begin
        bus_rdata = '0;
        if (slot == ADDR_W'(SLOT_ID0)) bus_rdata = ID_WORD[7:0];
        if (slot == ADDR_W'(SLOT_ID1)) bus_rdata = ID_WORD[15:8];
        if (slot == ADDR_W'(SLOT_ID2)) bus_rdata = ID_WORD[23:16];
        if (slot == ADDR_W'(SLOT_ID3)) bus_rdata = ID_WORD[31:24];
        if (sel_data) bus_rdata = rx_dout;
        if (sel_stat) bus_rdata = status;
        if (sel_bdlo) bus_rdata = baud_q[7:0];
        if (sel_bdhi) bus_rdata = baud_q[15:8];
    end

    // Transmit room with its enable must reach the interrupt pin.
    assert_tx_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && tx_req == 1'b0) |-> irq);

    // With both enables clear the interrupt stays low.
    assert_rx_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);

    // Level flags are mutually exclusive.
    assert_level_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_full, rx_one_free, rx_empty}));
endmodule

// File: tb/sim_uart_reg_frontend.sv
module sim_uart_reg_frontend;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] IDW        = 32'h5A01C37E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_frame_err = 1'b0;
    logic        tx_req;
    logic [7:0]  tx_byte;
    logic        tx_done = 1'b0;
    logic [15:0] baud_div;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    uart_reg_frontend u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_frame_err(rx_frame_err), .tx_req(tx_req), .tx_byte(tx_byte),
        .tx_done(tx_done), .baud_div(baud_div)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] st_exp(input bit fe, input bit oe, input bit rie,
                                          input int cnt, input bit tie, input bit tmt);
        return {tmt, tie, cnt == 0, cnt == 3, cnt == 4, rie, oe, fe};
    endfunction

    task automatic bus_write(input int slot, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(slot * 4); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int slot, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(slot * 4); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b, input bit fe);
        @(negedge clk);
        rx_byte = b; rx_frame_err = fe; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_frame_err = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        bus_read(5, d);
        chk("R12 status", d, 8'hA0);
        chk("R12 irq", irq, 0);
        chk("R12 tx_req", tx_req, 0);
        chk("R12 baud", baud_div, 0);

        // R1: identification slots and write immunity
        for (int s = 0; s < 4; s++) begin
            bus_write(s, 8'hFF ^ IDW[8*s +: 8]);
            bus_read(s, d);
            chk("R1 id", d, IDW[8*s +: 8]);
        end

        // R2: divisor bytes, several patterns
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = 16'h1234 * 16'(k + 1) + 16'(k);
            bus_write(6, v[7:0]);
            bus_write(7, v[15:8]);
            chk("R2 baud_div", baud_div, v);
            bus_read(6, d); chk("R2 low", d, v[7:0]);
            bus_read(7, d); chk("R2 high", d, v[15:8]);
        end

        // R3 R4 R8: fill levels 1..4, drain, then read empty
        for (int n = 1; n <= 4; n++) begin
            for (int i = 0; i < n; i++) begin
                push_rx(8'(n * 16 + i), 1'b0);
                bus_read(5, d);
                chk("R3 level after push", d, st_exp(0, 0, 0, i + 1, 0, 1));
            end
            for (int i = 0; i < n; i++) begin
                bus_read(4, d);
                chk("R4 order", d, 8'(n * 16 + i));
                bus_read(5, d);
                chk("R3 level after pop", d, st_exp(0, 0, 0, n - i - 1, 0, 1));
            end
            bus_read(4, d);
            chk("R8 empty read", d, 8'(n * 16 + n - 1));
            bus_read(5, d);
            chk("R8 still empty", d, 8'hA0);
        end

        // R5: overflow drops, keeps contents, flags
        for (int i = 0; i < 4; i++) push_rx(8'hA0 + 8'(i), 1'b0);
        push_rx(8'hEE, 1'b0);
        bus_read(5, d);
        chk("R5 overrun flag", d, st_exp(0, 1, 0, 4, 0, 1));
        for (int i = 0; i < 4; i++) begin
            bus_read(4, d);
            chk("R5 kept", d, 8'hA0 + 8'(i));
        end
        bus_read(4, d);
        chk("R5 dropped byte absent", d, 8'hA3);

        // R7: clear overrun by writing 0
        bus_write(5, 8'h00);
        bus_read(5, d);
        chk("R7 clear", d, 8'hA0);

        // R6: frame error stored and flagged
        push_rx(8'h5C, 1'b1);
        bus_read(5, d);
        chk("R6 frame flag", d, st_exp(1, 0, 0, 1, 0, 1));
        // R7: ones keep, read-only bits ignore writes
        bus_write(5, 8'h3B);
        bus_read(5, d);
        chk("R7 ro and keep", d, 8'h81);
        chk("R10 disabled", irq, 0);
        bus_write(5, 8'h05);
        chk("R10 error irq", irq, 1);
        bus_write(5, 8'h04);
        bus_read(5, d);
        chk("R7 ferr cleared", d, st_exp(0, 0, 1, 1, 0, 1));
        chk("R10 data irq", irq, 1);
        bus_read(4, d);
        chk("R6 byte stored", d, 8'h5C);
        chk("R10 irq drop", irq, 0);
        push_rx(8'h77, 1'b0);
        chk("R10 push irq", irq, 1);
        bus_read(4, d);
        chk("R10 pop irq", irq, 0);
        bus_write(5, 8'h00);
        push_rx(8'h78, 1'b0);
        chk("R10 masked", irq, 0);
        bus_read(4, d);

        // R9 R11: transmit handshake sweep
        bus_write(5, 8'h40);
        chk("R11 room irq", irq, 1);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b;
            b = 8'(k * 37 + 5);
            bus_write(4, b);
            chk("R9 tx_req", tx_req, 1);
            chk("R9 tx_byte", tx_byte, b);
            chk("R11 busy irq", irq, 0);
            bus_read(5, d);
            chk("R9 busy status", d, 8'h60);
            bus_write(4, ~b);
            chk("R9 ignored", tx_byte, b);
            pulse_done();
            chk("R9 done", tx_req, 0);
            chk("R11 room again", irq, 1);
            bus_read(5, d);
            chk("R9 empty status", d, 8'hE0);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule